// File: doc/BRIEF.md
# Coarse Fixed-Ratio Complex Mixer

This block shifts a complex baseband stream (signed I and Q samples with a valid strobe) in frequency by a fixed multiple of one eighth of the sample rate. It does not use a numerically controlled oscillator. A 3-bit phase counter selects the rotation angle, in 45° steps, for each sample. At those angles every sine and cosine value is 0, ±1 or ±√2/2, so the datapath only needs sign selection, shifts and one constant multiplier per term.

The shift is set by a 4-bit mode field and gated by a mixer enable. A separate fine-mixer enable input tells the block whether a fine frequency path elsewhere is in use. Only one of the two paths may run at a time. Any conflicting or reserved setting leaves the stream untouched and raises a sticky configuration-error flag.

Top module: `cmix_coarse`

## Requirements
- R1: While reset is asserted, and at release, valid_o, i_o, q_o and cfg_err_o are all zero.
- R2: Mode codes 1 through 7 select a shift of k·fs/8, where k equals the code. Code 2 gives +fs/4, code 4 gives fs/2 and code 6 gives −fs/4. On each valid sample the phase counter p (0..7, modulo 8) advances by k. It starts at 0 on the first valid sample after mixing becomes active.
- R3: For a valid sample at phase p, with angle θ = p·45°, C = cos θ and S = sin θ in Q15 (±1 = ±32768, ±√2/2 = ±23170, 0 = 0): i_o = floor((I·C − Q·S + 16384)/32768) and q_o = floor((I·S + Q·C + 16384)/32768).
- R4: Any result of R3 outside the signed W-bit range is clamped to the largest or smallest representable value.
- R5: valid_o equals valid_i from exactly two clock cycles earlier. i_o and q_o change only when a valid result is delivered.
- R6: When mix_en_i is low or the mode is 0, samples pass through unchanged with the same two-cycle latency, and the phase counter returns to 0.
- R7: Cycles with valid_i low do not advance the phase counter.
- R8: A nonzero mode while fine_en_i is high puts the block in bypass and sets cfg_err_o. fine_en_i with mode 0 is not an error.
- R9: Mode codes 8 to 15 (bit 3 set) behave as bypass and set cfg_err_o.
- R10: cfg_err_o rises one cycle after an offending setting is sampled. It then stays high until reset, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Shift select: 0 off, 1..7 = k·fs/8, 8..15 reserved |
| mix_en_i | input | 1 | Master mixer enable |
| fine_en_i | input | 1 | Fine mixer in use (conflict detection) |
| valid_i | input | 1 | Input sample strobe |
| i_i | input | W | In-phase input sample, signed |
| q_i | input | W | Quadrature input sample, signed |
| valid_o | output | 1 | Output sample strobe |
| i_o | output | W | In-phase mixed sample, signed |
| q_o | output | W | Quadrature mixed sample, signed |
| cfg_err_o | output | 1 | Sticky configuration error |

## Verification
The bench sweeps every shift code with full-range random samples and sparse valid strobes. This exposes a phase counter that advances on idle cycles or by the wrong step, which would give a result at the wrong angle. Full-scale pairs at the 45° phases drive the clamp: a design that wraps instead of saturating flips the sign of the output. Changes between bypass and active mode check that the phase restarts at 0, so a stale phase would rotate the first mixed sample. Fine-path conflicts, reserved codes and clearing by reset show whether the error flag is missed, fails to stick, or lets the stream be mixed anyway.

// File: rtl/cmix_pkg.sv
package cmix_pkg;

  localparam int unsigned FRAC = 15;
  localparam logic [15:0] RT_HALF = 16'h5A82;  // sqrt(2)/2 in Q15

  typedef enum logic [1:0] {
    MAG_ZERO = 2'd0,
    MAG_ONE  = 2'd1,
    MAG_HALF = 2'd2
  } mag_e;

  typedef struct packed {
    logic neg;
    mag_e mag;
  } coef_t;

  // cosine of p*45 degrees
  function automatic coef_t cos_of(input logic [2:0] p);
    coef_t c;
    c.neg = (p inside {3'd3, 3'd4, 3'd5});
    case (p)
      3'd0, 3'd4: c.mag = MAG_ONE;
      3'd2, 3'd6: c.mag = MAG_ZERO;
      default:    c.mag = MAG_HALF;
    endcase
    return c;
  endfunction

  function automatic coef_t sin_of(input logic [2:0] p);
    return cos_of(3'(p - 3'd2));
  endfunction

endpackage

// File: rtl/cmix_mode_dec.sv
module cmix_mode_dec (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] mode_i,
  input  logic       mix_en_i,
  input  logic       fine_en_i,
  output logic       active_o,
  output logic [2:0] step_o,
  output logic       cfg_err_o
);
  logic reserved, conflict, err_q;

  assign reserved = mode_i[3];
  assign conflict = fine_en_i && (mode_i != 4'd0);
  assign active_o = mix_en_i && !fine_en_i && !reserved && (mode_i[2:0] != 3'd0);
  assign step_o   = mode_i[2:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_q | reserved | conflict;
  end

  assign cfg_err_o = err_q;

  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);
  assert_conflict_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fine_en_i && mode_i != 4'd0) |=> cfg_err_o);
  assert_reserved_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[3] |=> cfg_err_o);
endmodule

// File: rtl/cmix_phase.sv
module cmix_phase #(
  parameter int PW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          valid_i,
  input  logic [PW-1:0] step_i,
  output logic [PW-1:0] phase_o
);
  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ph_q <= '0;
    else if (!active_i) ph_q <= '0;
    else if (valid_i)   ph_q <= ph_q + step_i;
  end

  assign phase_o = ph_q;

  assert_idle_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (phase_o == '0));
  assert_hold_on_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !valid_i) |=> $stable(phase_o));
  assert_step_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && valid_i) |=> (phase_o == PW'($past(phase_o) + $past(step_i))));
endmodule

// File: rtl/cmix_rot.sv
module cmix_rot
  import cmix_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic signed [W-1:0] i_i,
  input  logic signed [W-1:0] q_i,
  input  coef_t               cos_i,
  input  coef_t               sin_i,
  output logic                valid_o,
  output logic signed [W-1:0] i_o,
  output logic signed [W-1:0] q_o
);
  localparam int SW = W + FRAC + 2;
  localparam logic signed [SW-1:0] HALF_K = SW'(RT_HALF);
  localparam logic signed [SW-1:0] RND    = SW'(1) <<< (FRAC - 1);
  localparam logic signed [SW-1:0] MAXV   = {{(SW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV   = ~MAXV;

  function automatic logic signed [SW-1:0] scale(input logic signed [W-1:0] x, input coef_t c);
    logic signed [SW-1:0] xe, m;
    xe = SW'(x);
    case (c.mag)
      MAG_ONE:  m = xe <<< FRAC;
      MAG_HALF: m = xe * HALF_K;
      default:  m = '0;
    endcase
    return c.neg ? -m : m;
  endfunction

  logic signed [SW-1:0] acc_d [2];
  logic signed [SW-1:0] acc_q [2];
  logic signed [W-1:0]  res_q [2];
  logic                 v1_q, v2_q;

  always_comb begin
    acc_d[0] = scale(i_i, cos_i) - scale(q_i, sin_i);
    acc_d[1] = scale(i_i, sin_i) + scale(q_i, cos_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= valid_i;
      v2_q <= v1_q;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic signed [SW-1:0] rnd;
    logic signed [W-1:0]  sat;

    always_comb begin
      rnd = (acc_q[g] + RND) >>> FRAC;
      if (rnd > MAXV)      sat = MAXV[W-1:0];
      else if (rnd < MINV) sat = MINV[W-1:0];
      else                 sat = rnd[W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q[g] <= '0;
        res_q[g] <= '0;
      end else begin
        if (valid_i) acc_q[g] <= acc_d[g];
        if (v1_q)    res_q[g] <= sat;
      end
    end
  end

  assign valid_o = v2_q;
  assign i_o     = res_q[0];
  assign q_o     = res_q[1];

  assert_hold_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v1_q |=> ($stable(i_o) && $stable(q_o)));
endmodule

// File: rtl/cmix_coarse.sv
module cmix_coarse
  import cmix_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [3:0]          mode_i,
  input  logic                mix_en_i,
  input  logic                fine_en_i,
  input  logic                valid_i,
  input  logic signed [W-1:0] i_i,
  input  logic signed [W-1:0] q_i,
  output logic                valid_o,
  output logic signed [W-1:0] i_o,
  output logic signed [W-1:0] q_o,
  output logic                cfg_err_o
);
  localparam int PW = 3;

  logic          active;
  logic [PW-1:0] step, phase, ph_eff;
  coef_t         c_cos, c_sin;

  cmix_mode_dec i_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .mix_en_i  (mix_en_i),
    .fine_en_i (fine_en_i),
    .active_o  (active),
    .step_o    (step),
    .cfg_err_o (cfg_err_o)
  );

  cmix_phase #(.PW(PW)) i_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .valid_i  (valid_i),
    .step_i   (step),
    .phase_o  (phase)
  );

  // bypass rotates by zero degrees
  assign ph_eff = active ? phase : '0;
  assign c_cos  = cos_of(ph_eff);
  assign c_sin  = sin_of(ph_eff);

  cmix_rot #(.W(W)) i_rot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .i_i     (i_i),
    .q_i     (q_i),
    .cos_i   (c_cos),
    .sin_i   (c_sin),
    .valid_o (valid_o),
    .i_o     (i_o),
    .q_o     (q_o)
  );

  assert_valid_lat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ##1 valid_o);
  assert_no_spurious_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ##1 !valid_o);
  assert_bypass_exact_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mix_en_i) |=> ##1 ((i_o == $past(i_i, 2)) && (q_o == $past(q_i, 2))));
  assert_conflict_bypass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fine_en_i) |=> ##1 ((i_o == $past(i_i, 2)) && (q_o == $past(q_i, 2))));
endmodule

// File: tb/test_cmix_coarse.sv
module test_cmix_coarse;
  localparam int W = 16;
  localparam int LIM = 2 ** (W - 1);

  logic                clk = 1'b0;
  logic                rst_ni = 1'b0;
  logic [3:0]          mode_i = '0;
  logic                mix_en_i = 1'b0, fine_en_i = 1'b0, valid_i = 1'b0;
  logic signed [W-1:0] i_i = '0, q_i = '0;
  logic                valid_o, cfg_err_o;
  logic signed [W-1:0] i_o, q_o;

  always #10 clk = ~clk;

  cmix_coarse #(.W(W)) i_cmix_coarse (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .mix_en_i(mix_en_i),
    .fine_en_i(fine_en_i), .valid_i(valid_i), .i_i(i_i), .q_i(q_i),
    .valid_o(valid_o), .i_o(i_o), .q_o(q_o), .cfg_err_o(cfg_err_o)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  int    m_phase = 0;
  bit    m_err = 1'b0;
  bit    e1_v = 1'b0, e2_v = 1'b0;
  int    e1_i = 0, e2_i = 0, e1_q = 0, e2_q = 0;
  string e1_t = "", e2_t = "";

  function automatic int cos_q(input int p);
    case (p % 8)
      0: return 32768;
      1: return 23170;
      2: return 0;
      3: return -23170;
      4: return -32768;
      5: return -23170;
      6: return 0;
      default: return 23170;
    endcase
  endfunction

  function automatic int sin_q(input int p);
    return cos_q((p + 6) % 8);
  endfunction

  function automatic int rnd_sat(input longint acc, output bit clip);
    longint r;
    r = (acc + 64'sd16384) >>> 15;
    clip = 1'b0;
    if (r > LIM - 1) begin r = LIM - 1; clip = 1'b1; end
    if (r < -LIM)    begin r = -LIM;    clip = 1'b1; end
    return int'(r);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int rnd_smp();
    return int'($signed(16'($urandom())));
  endfunction

  // called at a negedge; checks outputs, drives new inputs, waits one cycle
  task automatic step(input bit v, input int mode, input bit mix, input bit fine,
                      input int iv, input int qv);
    bit act, res, conf, c1, c2;
    int p, ei, eq;
    chk(valid_o == e2_v, "R5 valid", int'(valid_o), int'(e2_v));
    if (e2_v) begin
      chk(int'(i_o) == e2_i, {e2_t, " i"}, int'(i_o), e2_i);
      chk(int'(q_o) == e2_q, {e2_t, " q"}, int'(q_o), e2_q);
    end
    chk(cfg_err_o == m_err, "R8/R9/R10 cfg_err", int'(cfg_err_o), int'(m_err));
    e2_v = e1_v; e2_i = e1_i; e2_q = e1_q; e2_t = e1_t;

    valid_i = v; mode_i = 4'(mode); mix_en_i = mix; fine_en_i = fine;
    i_i = W'(iv); q_i = W'(qv);

    res  = (mode >= 8);
    conf = fine && (mode != 0);
    act  = mix && !fine && !res && (mode != 0);
    p    = act ? m_phase : 0;
    ei = rnd_sat(longint'(iv) * cos_q(p) - longint'(qv) * sin_q(p), c1);
    eq = rnd_sat(longint'(iv) * sin_q(p) + longint'(qv) * cos_q(p), c2);
    e1_v = v; e1_i = ei; e1_q = eq;
    if (res)       e1_t = "R9 bypass";
    else if (conf) e1_t = "R8 bypass";
    else if (!act) e1_t = "R6 bypass";
    else if (c1 || c2) e1_t = "R4 clamp";
    else           e1_t = "R2/R3/R7 mix";
    if (!act)   m_phase = 0;
    else if (v) m_phase = (m_phase + mode) % 8;
    m_err = m_err | res | conf;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; valid_i = 1'b0; mode_i = '0; mix_en_i = 1'b0; fine_en_i = 1'b0;
    i_i = '0; q_i = '0;
    m_phase = 0; m_err = 1'b0; e1_v = 1'b0; e2_v = 1'b0;
    repeat (2) @(negedge clk);
    chk(valid_o == 1'b0, "R1 valid_o", int'(valid_o), 0);
    chk(i_o == '0, "R1 i_o", int'(i_o), 0);
    chk(q_o == '0, "R1 q_o", int'(q_o), 0);
    chk(cfg_err_o == 1'b0, "R1 cfg_err_o", int'(cfg_err_o), 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    @(negedge clk);
    do_reset();

    // bypass: mixer off, then mode 0
    for (int n = 0; n < 20; n++) step(1'b1, 2, 1'b0, 1'b0, rnd_smp(), rnd_smp());
    for (int n = 0; n < 10; n++) step(1'b1, 0, 1'b1, 1'b0, rnd_smp(), rnd_smp());

    // every shift code, continuous valid
    for (int k = 1; k < 8; k++)
      for (int n = 0; n < 16; n++) step(1'b1, k, 1'b1, 1'b0, rnd_smp(), rnd_smp());

    // sparse valid: phase must hold on gaps
    for (int n = 0; n < 40; n++) step(1'($urandom_range(0, 1)), 3, 1'b1, 1'b0, rnd_smp(), rnd_smp());

    // full-scale values at 45-degree phases
    step(1'b1, 0, 1'b1, 1'b0, 0, 0);
    for (int n = 0; n < 8; n++) step(1'b1, 1, 1'b1, 1'b0, -LIM, LIM - 1);
    for (int n = 0; n < 8; n++) step(1'b1, 1, 1'b1, 1'b0, LIM - 1, LIM - 1);
    for (int n = 0; n < 8; n++) step(1'b1, 3, 1'b1, 1'b0, -LIM, -LIM);

    // random configuration mix without errors
    for (int n = 0; n < 300; n++)
      step(1'($urandom_range(0, 3) != 0), $urandom_range(0, 7), 1'($urandom_range(0, 7) != 0),
           1'b0, rnd_smp(), rnd_smp());

    // fine enable with mode 0 is legal
    for (int n = 0; n < 5; n++) step(1'b1, 0, 1'b1, 1'b1, rnd_smp(), rnd_smp());
    // conflict: bypass and sticky flag
    for (int n = 0; n < 6; n++) step(1'b1, 5, 1'b1, 1'b1, rnd_smp(), rnd_smp());
    for (int n = 0; n < 12; n++) step(1'b1, 5, 1'b1, 1'b0, rnd_smp(), rnd_smp());
    for (int n = 0; n < 4; n++) step(1'b0, 0, 1'b0, 1'b0, 0, 0);

    // reset clears the flag; reserved codes
    do_reset();
    for (int n = 0; n < 4; n++) step(1'b1, 2, 1'b1, 1'b0, rnd_smp(), rnd_smp());
    for (int n = 0; n < 8; n++) step(1'b1, 8 + n, 1'b1, 1'b0, rnd_smp(), rnd_smp());
    for (int n = 0; n < 10; n++) step(1'b1, 6, 1'b1, 1'b0, rnd_smp(), rnd_smp());
    for (int n = 0; n < 3; n++) step(1'b0, 0, 1'b0, 1'b0, 0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule